// File: doc/BRIEF.md
# I2C Controller Register and Interrupt Front End

This block is the register file and interrupt logic that software sees in front of an I2C command sequencer. The command and data buffers and the bus engine are separate blocks. This block holds the control, clock-divider, SDA-hold, I/O-configuration and run registers. It also holds a status word whose event flags are sticky, and it combines two of those flags with per-flag enables into one interrupt line.

Software resets the sequencer by setting a self-clearing reset bit in the control word. The front end holds a reset strobe toward the engine for a fixed number of cycles. The bit reads back as 1 for that whole window, so software can poll it until it drops. Timing settings survive the reset. Event flags, the run bit and the live status fields do not.

The register port is a plain single-cycle 32-bit write port with a combinational read data output. It carries no data stream, so it has no valid/ready handshake. A write completes on the clock edge where `bus_wr` is high, and `bus_rdata` always reflects `bus_addr`.

Top module: `i2cfe_regs`

## Requirements
- R1: The control word at offset 0x10 stores core enable (bit 1), master mode (bit 2), done-interrupt enable (bit 11) and error-interrupt enable (bit 12). It drives `core_en_o` and `master_o` and reads back those bits, with all other bits except bit 0 reading 0.
- R2: Writing control bit 0 as 1 raises `soft_rst_o` for exactly RST_CYCLES cycles, starting the cycle after the write. Control bit 0 reads 1 during that window and 0 afterwards.
- R3: During a soft reset, the sticky flags and the run bit are cleared. Event pulses are ignored, and the status word reads 0 (busy, in-progress and command index masked). The divider, SDA hold, filter, I/O configuration and control enable bits keep their values.
- R4: Status at offset 0x0C shows the following. Live bits: busy input at bit 0, in-progress input at bit 1, and command index at bits 20:16. Sticky flags set by one-cycle event pulses: NACK at bit 2, transfer interrupt at bit 4, stop at bit 6, command done at bit 8 and error at bit 9.
- R5: Writing the status word clears only those sticky flags whose bit is 1 in the written data; 0 bits have no effect. An event arriving in the same cycle as its clear leaves the flag set.
- R6: The clock divider at offset 0x00 is 16 bits (written data bits 15:0, driving `clk_div_o`). Bits 31:16 read 0, and the value changes only on a write to its offset.
- R7: The SDA register at offset 0x18 holds an 8-bit hold delay in bits 7:0 (`sda_dly_o`) and a 2-bit SCL filter setting in bits 9:8 (`scl_filt_o`). Other bits read 0.
- R8: The I/O configuration register at offset 0x14 holds the low IO_W bits of the written data (`io_cfg_o`). Other bits read 0.
- R9: The run register at offset 0x1C is a single level bit at bit 0 driving `run_o`. It is set or cleared by writes.
- R10: `irq_o` is high exactly when (command done AND done-enable) OR (error AND error-enable). It is visible in the cycle after the flag or enable changes.
- R11: Reads from unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_nack_i | input | 1 | Pulse: address or data not acknowledged |
| evt_xfer_i | input | 1 | Pulse: byte transfer interrupt |
| evt_stop_i | input | 1 | Pulse: stop condition seen |
| evt_done_i | input | 1 | Pulse: command buffer finished |
| evt_err_i | input | 1 | Pulse: bus error |
| busy_i | input | 1 | Live bus-busy level |
| tip_i | input | 1 | Live transfer-in-progress level |
| cmd_idx_i | input | IDX_W | Current command index from sequencer |
| soft_rst_o | output | 1 | Reset strobe to sequencer and engine |
| core_en_o | output | 1 | Core enable |
| master_o | output | 1 | Master mode select |
| run_o | output | 1 | Command buffer run request |
| clk_div_o | output | 16 | SCL clock divider |
| sda_dly_o | output | 8 | SDA hold delay |
| scl_filt_o | output | 2 | SCL glitch filter setting |
| io_cfg_o | output | IO_W | Pad I/O configuration |
| irq_o | output | 1 | Combined interrupt |

## Verification
A lost or stuck sticky flag shows in the next status read and, for done and error, on `irq_o` one cycle after the event or clear. A soft-reset counter that is off by one shows as `soft_rst_o` and control bit 0 dropping a cycle early or late, which the bench checks cycle by cycle across the window. A reset that wipes too much or too little shows in the first reads after the window: the divider, delay or enables go missing, or stale flags survive. Decode faults appear at once as wrong read-back widths or as writes leaking into a neighbouring offset.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
  localparam logic [7:0] OFS_DIV  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_IO   = 8'h14;
  localparam logic [7:0] OFS_SDA  = 8'h18;
  localparam logic [7:0] OFS_RUN  = 8'h1C;

  localparam int unsigned CB_RST    = 0;
  localparam int unsigned CB_EN     = 1;
  localparam int unsigned CB_MASTER = 2;
  localparam int unsigned CB_DONEEN = 11;
  localparam int unsigned CB_ERREN  = 12;

  localparam int unsigned SB_BUSY = 0;
  localparam int unsigned SB_TIP  = 1;
  localparam int unsigned SB_IDX  = 16;

  localparam int unsigned NFLAG = 5;
  // flag index: 0 nack, 1 xfer, 2 stop, 3 done, 4 err
  localparam int unsigned FL_DONE = 3;
  localparam int unsigned FL_ERR  = 4;
  localparam int unsigned FLAG_POS [NFLAG] = '{2, 4, 6, 8, 9};
endpackage

// File: rtl/i2cfe_ctrl.sv
module i2cfe_ctrl
  import i2cfe_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_run,
  input  logic [31:0] wdata,
  output logic        soft_rst,
  output logic        core_en,
  output logic        master,
  output logic        done_en,
  output logic        err_en,
  output logic        run,
  output logic [31:0] ctrl_rd
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] rst_cnt;
  logic          rst_req;

  assign rst_req  = wr_ctrl && wdata[CB_RST];
  assign soft_rst = (rst_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt <= '0;
      core_en <= 1'b0;
      master  <= 1'b0;
      done_en <= 1'b0;
      err_en  <= 1'b0;
      run     <= 1'b0;
    end else begin
      if (rst_req)       rst_cnt <= CW'(RST_CYCLES);
      else if (soft_rst) rst_cnt <= rst_cnt - 1'b1;
      if (wr_ctrl) begin
        core_en <= wdata[CB_EN];
        master  <= wdata[CB_MASTER];
        done_en <= wdata[CB_DONEEN];
        err_en  <= wdata[CB_ERREN];
      end
      if (soft_rst)    run <= 1'b0;
      else if (wr_run) run <= wdata[0];
    end
  end

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[CB_RST]    = soft_rst;
    ctrl_rd[CB_EN]     = core_en;
    ctrl_rd[CB_MASTER] = master;
    ctrl_rd[CB_DONEEN] = done_en;
    ctrl_rd[CB_ERREN]  = err_en;
  end

  AST_RST_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> soft_rst); // R2
  AST_RUN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !run); // R3
  AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(core_en) && $stable(done_en) && $stable(err_en)); // R1
endmodule

// File: rtl/i2cfe_status.sv
module i2cfe_status
  import i2cfe_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [NFLAG-1:0] evt,
  input  logic             clr_wr,
  input  logic [31:0]      wdata,
  input  logic             busy,
  input  logic             tip,
  input  logic [IDX_W-1:0] idx,
  output logic [NFLAG-1:0] flags,
  output logic [31:0]      stat_rd
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    localparam int unsigned POS = FLAG_POS[g];
    logic clr_hit;
    assign clr_hit = clr_wr && wdata[POS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags[g] <= 1'b0;
      else if (soft_rst) flags[g] <= 1'b0;
      else if (evt[g])   flags[g] <= 1'b1;
      else if (clr_hit)  flags[g] <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flags[g] && !soft_rst && !clr_hit |=> flags[g]); // R5
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] && !soft_rst |=> flags[g]); // R4
    AST_RST_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !flags[g]); // R3
  end

  always_comb begin
    stat_rd = '0;
    if (!soft_rst) begin
      stat_rd[SB_BUSY] = busy;
      stat_rd[SB_TIP]  = tip;
      stat_rd[SB_IDX +: IDX_W] = idx;
      for (int i = 0; i < NFLAG; i++) stat_rd[FLAG_POS[i]] = flags[i];
    end
  end
endmodule

// File: rtl/i2cfe_timing.sv
module i2cfe_timing #(
  parameter int unsigned IO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_div,
  input  logic            wr_sda,
  input  logic            wr_io,
  input  logic [31:0]     wdata,
  output logic [15:0]     clk_div,
  output logic [7:0]      sda_dly,
  output logic [1:0]      scl_filt,
  output logic [IO_W-1:0] io_cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_div  <= '0;
      sda_dly  <= '0;
      scl_filt <= '0;
      io_cfg   <= '0;
    end else begin
      if (wr_div) clk_div <= wdata[15:0];
      if (wr_sda) begin
        sda_dly  <= wdata[7:0];
        scl_filt <= wdata[9:8];
      end
      if (wr_io) io_cfg <= wdata[IO_W-1:0];
    end
  end

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div |=> $stable(clk_div)); // R6
  AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sda |=> $stable(sda_dly) && $stable(scl_filt)); // R7
endmodule

// File: rtl/i2cfe_regs.sv
module i2cfe_regs
  import i2cfe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned IO_W       = 8,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_nack_i,
  input  logic              evt_xfer_i,
  input  logic              evt_stop_i,
  input  logic              evt_done_i,
  input  logic              evt_err_i,
  input  logic              busy_i,
  input  logic              tip_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  output logic              soft_rst_o,
  output logic              core_en_o,
  output logic              master_o,
  output logic              run_o,
  output logic [15:0]       clk_div_o,
  output logic [7:0]        sda_dly_o,
  output logic [1:0]        scl_filt_o,
  output logic [IO_W-1:0]   io_cfg_o,
  output logic              irq_o
);
  logic sel_div, sel_stat, sel_ctrl, sel_io, sel_sda, sel_run;
  logic done_en, err_en;
  logic [NFLAG-1:0] flags, evt;
  logic [31:0] ctrl_rd, stat_rd;

  assign sel_div  = (bus_addr == ADDR_W'(OFS_DIV));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_io   = (bus_addr == ADDR_W'(OFS_IO));
  assign sel_sda  = (bus_addr == ADDR_W'(OFS_SDA));
  assign sel_run  = (bus_addr == ADDR_W'(OFS_RUN));

  assign evt = {evt_err_i, evt_done_i, evt_stop_i, evt_xfer_i, evt_nack_i};

  i2cfe_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(bus_wr && sel_ctrl), .wr_run(bus_wr && sel_run), .wdata(bus_wdata),
    .soft_rst(soft_rst_o), .core_en(core_en_o), .master(master_o),
    .done_en(done_en), .err_en(err_en), .run(run_o), .ctrl_rd(ctrl_rd)
  );

  i2cfe_status #(.IDX_W(IDX_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_o), .evt(evt),
    .clr_wr(bus_wr && sel_stat), .wdata(bus_wdata),
    .busy(busy_i), .tip(tip_i), .idx(cmd_idx_i),
    .flags(flags), .stat_rd(stat_rd)
  );

  i2cfe_timing #(.IO_W(IO_W)) u_tim (
    .clk(clk), .rst_n(rst_n),
    .wr_div(bus_wr && sel_div), .wr_sda(bus_wr && sel_sda), .wr_io(bus_wr && sel_io),
    .wdata(bus_wdata),
    .clk_div(clk_div_o), .sda_dly(sda_dly_o), .scl_filt(scl_filt_o), .io_cfg(io_cfg_o)
  );

  assign irq_o = (flags[FL_DONE] && done_en) || (flags[FL_ERR] && err_en);

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel_div:  bus_rdata = {16'h0, clk_div_o};
      sel_stat: bus_rdata = stat_rd;
      sel_ctrl: bus_rdata = ctrl_rd;
      sel_io:   bus_rdata = 32'(io_cfg_o);
      sel_sda:  bus_rdata = {22'h0, scl_filt_o, sda_dly_o};
      sel_run:  bus_rdata = {31'h0, run_o};
      default:  bus_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (done_en || err_en)); // R10
  AST_IRQ_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !irq_o); // R3
endmodule

// File: tb/tb_i2cfe_regs.sv
`timescale 1ns/1ps
module tb_i2cfe_regs;
  localparam int unsigned RSTC = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [4:0] evt = '0;
  logic busy = 1'b0, tip = 1'b0;
  logic [4:0] idx = '0;
  logic soft_rst, core_en, master, run, irq;
  logic [15:0] clk_div;
  logic [7:0] sda_dly, io_cfg;
  logic [1:0] filt;
  int errors = 0, checks = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  i2cfe_regs #(.RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_nack_i(evt[0]), .evt_xfer_i(evt[1]), .evt_stop_i(evt[2]),
    .evt_done_i(evt[3]), .evt_err_i(evt[4]),
    .busy_i(busy), .tip_i(tip), .cmd_idx_i(idx),
    .soft_rst_o(soft_rst), .core_en_o(core_en), .master_o(master), .run_o(run),
    .clk_div_o(clk_div), .sda_dly_o(sda_dly), .scl_filt_o(filt),
    .io_cfg_o(io_cfg), .irq_o(irq)
  );

  typedef struct packed { logic [7:0] a; logic [31:0] w; logic [31:0] e; } vec_t;
  localparam vec_t VECS [11] = '{
    '{8'h00, 32'hABCD1234, 32'h0000_1234},  // R6
    '{8'h00, 32'hFFFFFFFF, 32'h0000_FFFF},  // R6
    '{8'h18, 32'hFFFFFF5A, 32'h0000_035A},  // R7
    '{8'h18, 32'h00000100, 32'h0000_0100},  // R7
    '{8'h14, 32'h123456C3, 32'h0000_00C3},  // R8
    '{8'h10, 32'hFFFFFFFE, 32'h0000_1806},  // R1
    '{8'h10, 32'h00000804, 32'h0000_0804},  // R1
    '{8'h1C, 32'hFFFFFFFF, 32'h0000_0001},  // R9
    '{8'h1C, 32'h00000002, 32'h0000_0000},  // R9
    '{8'h20, 32'hFFFFFFFF, 32'h0000_0000},  // R11
    '{8'h04, 32'hFFFFFFFF, 32'h0000_0000}   // R11
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state R1 R4 R6 R10
    rd(8'h10, d); chk("R1 ctrl reset", d, 32'h0);
    rd(8'h0C, d); chk("R4 status reset", d, 32'h0);
    rd(8'h00, d); chk("R6 div reset", d, 32'h0);
    chk("R10 irq reset", {31'h0, irq}, 32'h0);

    // table walk
    foreach (VECS[i]) begin
      wr(VECS[i].a, VECS[i].w);
      rd(VECS[i].a, d);
      chk($sformatf("table[%0d] addr %h", i, VECS[i].a), d, VECS[i].e);
    end
    // R11: unmapped writes left neighbours untouched
    rd(8'h00, d); chk("R11 div untouched", d, 32'h0000_FFFF);
    rd(8'h18, d); chk("R11 sda untouched", d, 32'h0000_0100);
    chk("R1 outputs", {29'h0, core_en, master, 1'b0}, 32'h2);
    chk("R7 pins", {22'h0, filt, sda_dly}, 32'h100);
    chk("R8 pin", {24'h0, io_cfg}, 32'hC3);

    // R4 sticky flags and live fields
    wr(8'h10, 32'h0);
    busy = 1'b1; tip = 1'b1; idx = 5'd5;
    pulse(5'b11111);
    rd(8'h0C, d); chk("R4 all flags", d, 32'h0005_0357);
    chk("R10 no enable", {31'h0, irq}, 32'h0);
    // R5 write-1-to-clear
    wr(8'h0C, 32'h0000_0100);
    rd(8'h0C, d); chk("R5 clear done only", d, 32'h0005_0257);
    wr(8'h0C, 32'h0);
    rd(8'h0C, d); chk("R5 zero write", d, 32'h0005_0257);
    // R10 error enable
    wr(8'h10, 32'h0000_1000);
    chk("R10 err irq", {31'h0, irq}, 32'h1);
    wr(8'h0C, 32'h0000_0200);
    chk("R10 err cleared", {31'h0, irq}, 32'h0);
    rd(8'h0C, d); chk("R5 err cleared", d, 32'h0005_0057);
    // R5 event and clear in the same cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0000_0200; evt = 5'b10000;
    @(negedge clk);
    bus_wr = 1'b0; evt = '0;
    rd(8'h0C, d); chk("R5 set wins", d, 32'h0005_0257);
    chk("R10 err again", {31'h0, irq}, 32'h1);
    // R10 done enable
    wr(8'h10, 32'h0000_0800);
    chk("R10 done en, done clear", {31'h0, irq}, 32'h0);
    pulse(5'b01000);
    chk("R10 done irq", {31'h0, irq}, 32'h1);

    // R2 R3 soft reset
    wr(8'h00, 32'h0000_55AA);
    wr(8'h18, 32'h0000_022A);
    wr(8'h1C, 32'h1);
    wr(8'h10, 32'h0000_1807);
    for (int k = 0; k < RSTC; k++) begin
      chk($sformatf("R2 strobe cycle %0d", k), {31'h0, soft_rst}, 32'h1);
      rd(8'h10, d); chk("R2 bit reads 1", d, 32'h0000_1807);
      rd(8'h0C, d); chk("R3 status masked", d, 32'h0);
      evt = (k == 1) ? 5'b11000 : 5'b0;
      @(negedge clk);
    end
    evt = '0;
    chk("R2 strobe ended", {31'h0, soft_rst}, 32'h0);
    rd(8'h10, d); chk("R2 bit cleared", d, 32'h0000_1806);
    rd(8'h0C, d); chk("R3 flags wiped", d, 32'h0005_0003);
    chk("R3 irq low", {31'h0, irq}, 32'h0);
    rd(8'h00, d); chk("R3 div kept", d, 32'h0000_55AA);
    rd(8'h18, d); chk("R3 sda kept", d, 32'h0000_022A);
    rd(8'h14, d); chk("R3 io kept", d, 32'h0000_00C3);
    rd(8'h1C, d); chk("R3 run cleared", d, 32'h0);
    chk("R9 run pin", {31'h0, run}, 32'h0);
    chk("R6 div pin", {16'h0, clk_div}, 32'h55AA);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule